// File: doc/BRIEF.md
# Supervisor Trap-Control Gate

This block decides, for each privileged operation handed to it by the decoder, whether that operation must raise an illegal-instruction exception because of three trap-control bits kept in the machine status register. The three bits are a virtual-memory trap bit, a timed-wait bit and a supervisor-return trap bit. The virtual-memory trap bit covers accesses to the address-translation CSR and the translation fence. The timed-wait bit covers wait-for-interrupt. The supervisor-return trap bit covers SRET. The gate applies the bits only while the hart runs at supervisor privilege. Machine mode is never trapped by them.

The decoder raises one strobe per operation, together with the current privilege. The gate answers with a combinational illegal flag in the same cycle. The one exception is the timed wait. A WFI in supervisor mode with the timed-wait bit set may wait at most `WAIT_LIMIT` cycles before it traps. A limit of zero makes it trap at once. While a WFI is waiting, the gate drives a stall signal. It drives a completion pulse when an interrupt arrives. Status-register writes load the three bits, and the new values govern the next cycle. A build without supervisor mode keeps all three bits at zero.

Top module: `vtrap_gate`

## Requirements
- R1: With the virtual-memory trap bit set and privilege S (encoding 2'b01), a translation-CSR access strobe makes illegal_o high in that same cycle. With the bit clear, illegal_o stays low.
- R2: With the virtual-memory trap bit set and privilege S, a translation-fence strobe makes illegal_o high in that same cycle. With the bit clear, illegal_o stays low.
- R3: With the return trap bit set and privilege S, an SRET strobe makes illegal_o high in that same cycle. With the bit clear, illegal_o stays low.
- R4: With the timed-wait bit clear, a WFI held without a pending interrupt keeps wfi_stall_o high and illegal_o low for as long as it is held. A pending interrupt then makes wfi_done_o high and wfi_stall_o low in that cycle.
- R5: With the timed-wait bit set, privilege S and WAIT_LIMIT = N > 0, a WFI first presented in cycle 0 with no interrupt stalls in cycles 0 to N-1. In cycle N it drives illegal_o high and wfi_stall_o low.
- R6: An interrupt that arrives in a cycle before the limit completes the WFI without a trap. The count clears, so the next WFI again gets the full N-cycle window.
- R7: With WAIT_LIMIT = 0, a WFI in S-mode with the timed-wait bit set drives illegal_o high in its first cycle, even when an interrupt is pending.
- R8: With HAS_SMODE = 0, all three trap bits read 0 whatever is written, and no operation raises illegal_o.
- R9: At privilege M (2'b11) or U (2'b00), illegal_o stays low for every strobe, whatever the trap bits hold.
- R10: A status write loads the virtual-memory trap bit from data bit 20, the timed-wait bit from bit 21 and the return trap bit from bit 22. Other data bits have no effect. A strobe in the cycle of the write still sees the old values, and the new values apply from the next cycle.
- R11: wfi_done_o and wfi_stall_o are never high together, and both are low when wfi_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| satp_acc_i | input | 1 | Translation-CSR read or write strobe |
| sfence_i | input | 1 | Translation-fence strobe |
| sret_i | input | 1 | Supervisor-return strobe |
| wfi_i | input | 1 | WFI held while the instruction waits |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| status_we_i | input | 1 | Status-register write enable |
| status_wdata_i | input | XLEN | Status-register write data |
| illegal_o | output | 1 | Raise illegal-instruction exception |
| wfi_stall_o | output | 1 | WFI still waiting |
| wfi_done_o | output | 1 | WFI completed by an interrupt |
| tvm_o | output | 1 | Stored virtual-memory trap bit |
| tw_o | output | 1 | Stored timed-wait bit |
| tsr_o | output | 1 | Stored return trap bit |

## Verification
On every cycle, the assertions check that a trap occurs only at supervisor privilege and that the wait counter never passes its limit. They also check that it clears after a timeout, that completion and stall exclude each other, and that a status write lands in the stored bits one cycle later. Only the bench's scenarios can show the exact timeout cycle, the fresh window after an interrupt, the immediate trap at a zero limit and the read-as-zero build. The same holds for the per-strobe outcomes in each privilege.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int TVM_POS = 20;
  localparam int TW_POS  = 21;
  localparam int TSR_POS = 22;

  typedef struct packed {
    logic tsr;
    logic tw;
    logic tvm;
  } tctl_t;

  // A trap-control bit intercepts an operation only at supervisor level.
  function automatic logic s_intercept(input logic [1:0] priv, input logic ctl,
                                       input logic strobe);
    return strobe && ctl && (priv == PRIV_S);
  endfunction
endpackage

// File: rtl/trapctl_regs.sv
module trapctl_regs
  import trapctl_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output tctl_t           ctl_o
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[XLEN-1:TSR_POS+1], wdata_i[TVM_POS-1:0]};

  generate
    if (HAS_SMODE) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_o <= '0;
        else if (we_i) begin
          ctl_o.tvm <= wdata_i[TVM_POS];
          ctl_o.tw  <= wdata_i[TW_POS];
          ctl_o.tsr <= wdata_i[TSR_POS];
        end
      end

      // R10
      write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ctl_o == {$past(wdata_i[TSR_POS]), $past(wdata_i[TW_POS]),
                            $past(wdata_i[TVM_POS])}));
    end else begin : g_zero
      logic unused_clk;
      assign unused_clk = ^{clk, rst_n, we_i, wdata_i[TSR_POS:TVM_POS]};
      assign ctl_o = '0;
    end
  endgenerate
endmodule

// File: rtl/wfi_timer.sv
module wfi_timer #(
  parameter int WAIT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_i,
  input  logic irq_i,
  input  logic timed_i,
  output logic done_o,
  output logic stall_o,
  output logic expire_o
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(WAIT_LIMIT);
  localparam bit ZERO_LIM = (WAIT_LIMIT == 0);

  logic [CNT_W-1:0] cnt;

  // With a zero limit the timed case traps before any interrupt can finish it.
  assign done_o   = wfi_i && irq_i && !(timed_i && ZERO_LIM);
  assign expire_o = wfi_i && timed_i && (cnt == LIM) && (ZERO_LIM || !irq_i);
  assign stall_o  = wfi_i && !done_o && !expire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!wfi_i || done_o || expire_o) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LIM);
  // R6
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o || done_o) |=> (cnt == '0));
  // R11
  done_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && stall_o) && (wfi_i || (!done_o && !stall_o)));
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trapctl_pkg::*;
(
  input  logic [1:0] priv_i,
  input  tctl_t      ctl_i,
  input  logic       satp_acc_i,
  input  logic       sfence_i,
  input  logic       sret_i,
  input  logic       wfi_expire_i,
  output logic       timed_o,
  output logic       illegal_o
);
  assign timed_o = (priv_i == PRIV_S) && ctl_i.tw;

  always_comb begin
    illegal_o = s_intercept(priv_i, ctl_i.tvm, satp_acc_i | sfence_i)
              | s_intercept(priv_i, ctl_i.tsr, sret_i)
              | wfi_expire_i;
  end
endmodule

// File: rtl/vtrap_gate.sv
module vtrap_gate
  import trapctl_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_SMODE  = 1'b1,
  parameter int WAIT_LIMIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_i,
  input  logic            satp_acc_i,
  input  logic            sfence_i,
  input  logic            sret_i,
  input  logic            wfi_i,
  input  logic            irq_pend_i,
  input  logic            status_we_i,
  input  logic [XLEN-1:0] status_wdata_i,
  output logic            illegal_o,
  output logic            wfi_stall_o,
  output logic            wfi_done_o,
  output logic            tvm_o,
  output logic            tw_o,
  output logic            tsr_o
);
  tctl_t ctl;
  logic  timed, wfi_expire;

  trapctl_regs #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(status_we_i), .wdata_i(status_wdata_i),
    .ctl_o(ctl)
  );

  trap_decide u_decide (
    .priv_i(priv_i), .ctl_i(ctl), .satp_acc_i(satp_acc_i), .sfence_i(sfence_i),
    .sret_i(sret_i), .wfi_expire_i(wfi_expire), .timed_o(timed),
    .illegal_o(illegal_o)
  );

  wfi_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .irq_i(irq_pend_i),
    .timed_i(timed), .done_o(wfi_done_o), .stall_o(wfi_stall_o),
    .expire_o(wfi_expire)
  );

  assign tvm_o = ctl.tvm;
  assign tw_o  = ctl.tw;
  assign tsr_o = ctl.tsr;

  // R9
  s_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (priv_i == PRIV_S));
  // R8
  no_smode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_SMODE |-> (!illegal_o && !tvm_o && !tw_o && !tsr_o));
endmodule

// File: tb/sim_vtrap_gate.sv
`timescale 1ns/1ps
module sim_vtrap_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'b01;
  logic        satp = 1'b0, sfence = 1'b0, sret = 1'b0, wfi = 1'b0, irq = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        ill0, stl0, dn0, tvm0, tw0, tsr0;
  logic        ill1, stl1, dn1, tvm1, tw1, tsr1;
  logic        ill2, stl2, dn2, tvm2, tw2, tsr2;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  vtrap_gate #(.WAIT_LIMIT(4)) u0 (.clk, .rst_n, .priv_i(priv), .satp_acc_i(satp),
    .sfence_i(sfence), .sret_i(sret), .wfi_i(wfi), .irq_pend_i(irq),
    .status_we_i(we), .status_wdata_i(wdata), .illegal_o(ill0), .wfi_stall_o(stl0),
    .wfi_done_o(dn0), .tvm_o(tvm0), .tw_o(tw0), .tsr_o(tsr0));
  vtrap_gate #(.WAIT_LIMIT(0)) u1 (.clk, .rst_n, .priv_i(priv), .satp_acc_i(satp),
    .sfence_i(sfence), .sret_i(sret), .wfi_i(wfi), .irq_pend_i(irq),
    .status_we_i(we), .status_wdata_i(wdata), .illegal_o(ill1), .wfi_stall_o(stl1),
    .wfi_done_o(dn1), .tvm_o(tvm1), .tw_o(tw1), .tsr_o(tsr1));
  vtrap_gate #(.HAS_SMODE(1'b0)) u2 (.clk, .rst_n, .priv_i(priv), .satp_acc_i(satp),
    .sfence_i(sfence), .sret_i(sret), .wfi_i(wfi), .irq_pend_i(irq),
    .status_we_i(we), .status_wdata_i(wdata), .illegal_o(ill2), .wfi_stall_o(stl2),
    .wfi_done_o(dn2), .tvm_o(tvm2), .tw_o(tw2), .tsr_o(tsr2));

  // {priv[1:0], satp, sfence, sret, tvm, tsr, expected illegal}
  localparam logic [7:0] VEC [10] = '{
    8'b01_100_101, 8'b01_100_000, 8'b01_010_101, 8'b01_010_000,
    8'b01_001_011, 8'b01_001_000, 8'b11_100_110, 8'b11_001_110,
    8'b00_010_100, 8'b01_001_100
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Drive a status write at the current falling edge, hold for one cycle.
  task automatic write_status(input logic b_tvm, input logic b_tw, input logic b_tsr);
    wdata = '0;
    wdata[20] = b_tvm; wdata[21] = b_tw; wdata[22] = b_tsr;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(ill0, 1'b0, "reset illegal R9");
    check(tvm0 | tw0 | tsr0, 1'b0, "reset bits R10");
    check(stl0 | dn0, 1'b0, "reset wfi idle R11");
    @(negedge clk);

    // Table of single-strobe cases: R1 R2 R3 R9, and R8 on the S-less build
    for (int i = 0; i < 10; i++) begin
      write_status(VEC[i][2], 1'b0, VEC[i][1]);
      priv = VEC[i][7:6]; satp = VEC[i][5]; sfence = VEC[i][4]; sret = VEC[i][3];
      #1;
      check(ill0, VEC[i][0], $sformatf("vector %0d R1 R2 R3 R9", i));
      check(ill2, 1'b0, $sformatf("vector %0d no S-mode R8", i));
      @(negedge clk);
      satp = 0; sfence = 0; sret = 0; priv = 2'b01;
    end

    // R10: bit positions, old value in the write cycle, new value next cycle
    write_status(1'b0, 1'b0, 1'b0);
    wdata = 32'h0F88_0000 | 32'h0008_FFFF; // bits 23..27,19, low bits: no trap bits
    we = 1'b1; satp = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    check(tvm0 | tw0 | tsr0, 1'b0, "unrelated bits ignored R10");
    @(negedge clk);
    wdata = 32'h0010_0000; we = 1'b1; #1;
    check(ill0, 1'b0, "write cycle uses old bit R10");
    @(negedge clk); we = 1'b0; #1;
    check(ill0, 1'b1, "next cycle uses new bit R10");
    check(tvm2, 1'b0, "S-less bit reads zero R8");
    @(negedge clk); satp = 1'b0;
    write_status(1'b0, 1'b1, 1'b1); #1;
    check(tw0 & tsr0 & !tvm0, 1'b1, "bits 21/22 R10");

    // R5 + R7: timed wait, limit 4 on u0 and 0 on u1
    wfi = 1'b1;
    for (int c = 0; c <= 4; c++) begin
      #1;
      check(ill0, c == 4, $sformatf("timed wait cycle %0d illegal R5", c));
      check(stl0, c != 4, $sformatf("timed wait cycle %0d stall R5", c));
      if (c == 0) check(ill1, 1'b1, "zero limit traps first cycle R7");
      @(negedge clk);
    end
    wfi = 1'b0; #1;
    check(stl0 | dn0, 1'b0, "idle after wfi R11");
    @(negedge clk);

    // R7: zero limit still traps with an interrupt pending
    wfi = 1'b1; irq = 1'b1; #1;
    check(ill1, 1'b1, "zero limit beats interrupt R7");
    check(dn0, 1'b1, "interrupt completes wfi R6");
    @(negedge clk); wfi = 1'b0; irq = 1'b0;
    @(negedge clk);

    // R6: interrupt at cycle 2, then fresh full window
    wfi = 1'b1;
    @(negedge clk); @(negedge clk);
    irq = 1'b1; #1;
    check(dn0, 1'b1, "early interrupt done R6");
    check(ill0, 1'b0, "early interrupt no trap R6");
    @(negedge clk); irq = 1'b0; wfi = 1'b0;
    @(negedge clk); wfi = 1'b1;
    for (int c = 0; c <= 4; c++) begin
      #1;
      check(ill0, c == 4, $sformatf("fresh window cycle %0d R6", c));
      @(negedge clk);
    end
    wfi = 1'b0;

    // R4: timed-wait clear, long wait then interrupt
    write_status(1'b0, 1'b0, 1'b0);
    wfi = 1'b1;
    for (int c = 0; c < 8; c++) begin
      #1;
      check(stl0 & !ill0 & !ill1, 1'b1, $sformatf("untimed wait cycle %0d R4", c));
      @(negedge clk);
    end
    irq = 1'b1; #1;
    check(dn0 & !stl0, 1'b1, "untimed wait completes R4");
    @(negedge clk); wfi = 1'b0; irq = 1'b0;

    // R9: timed-wait bit in M-mode has no effect
    write_status(1'b0, 1'b1, 1'b0);
    priv = 2'b11; wfi = 1'b1;
    for (int c = 0; c < 6; c++) begin
      #1;
      check(ill0 | ill1, 1'b0, $sformatf("M-mode wfi cycle %0d R9", c));
      @(negedge clk);
    end
    wfi = 1'b0; priv = 2'b01;
    @(negedge clk);
    summary();
  end
endmodule